// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps a free-running nanosecond time of day for a precision time protocol clock. Internally it holds a 96-bit accumulator made of a 64-bit whole-nanosecond count and a 32-bit fraction of a nanosecond. On every core clock cycle in which counting is enabled, a programmable increment in 32.32 fixed point is added to the accumulator. Because the increment carries a fraction, the counter's long-term rate can be matched to any core clock frequency and trimmed finely by software. The nominal increment is (10^9 << 32) divided by the core clock frequency in Hz; a 1 GHz clock therefore uses 0x0000_0001_0000_0000.

Software reaches the block through a simple register port: a request is a single-cycle valid pulse with a write flag, an address and 64-bit write data, and read data appears registered one cycle after a read request. Software can enable or stop counting, load either part of the accumulator, read both parts back, and rewrite the increment at any time to steer the frequency without disturbing the time already accumulated.

Top module: `tod_counter`

## Requirements
- R1: After reset the accumulator, the increment and the enable bit are zero, so reads of every mapped offset return zero.
- R2: Offset 0xF00 is the control register, whose bit 0 enables counting and whose other bits read as zero; offset 0xF18 holds the 64-bit increment (bits 63:32 whole ns, bits 31:0 fraction) and reads back exactly as written.
- R3: A read request returns its data on reg_rdata in the cycle after the request, showing the state from before the update made on the request's clock edge.
- R4: While the enable bit is set and no clock write occurs, each cycle adds the increment to the 96-bit accumulator, with the fraction carrying into the whole count; a write to the control register takes effect from the next cycle.
- R5: While the enable bit is clear the accumulator keeps its value, whatever the increment holds.
- R6: A read of offset 0xF10 returns the 64-bit whole-nanosecond count; a read of offset 0xF08 returns the 32-bit fraction in bits 31:0 with bits 63:32 zero.
- R7: After N enabled cycles from a zero accumulator, the whole count equals floor(N × increment / 2^32) and the fraction equals (N × increment) mod 2^32, including for non-integer increments.
- R8: A write to 0xF10 loads the whole count from bits 63:0 and a write to 0xF08 loads the fraction from bits 31:0, ignoring bits 63:32; in a cycle with such a write no increment is added and the other part keeps its value.
- R9: A write to the increment register applies from the next cycle: the old increment is added in the cycle of the write, and the accumulated time is not changed by the write.
- R10: Reads of any other offset (including unaligned ones such as 0xF04) return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_vld | input | 1 | Register request valid for one cycle |
| reg_wr | input | 1 | 1 = write request, 0 = read request |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, valid the cycle after a read request |

## Verification
The counting step and a software write to the clock or the increment can land on the same clock edge. The bench provokes this by writing the whole count, the fraction and the increment while counting is enabled, at a known number of cycles after enabling, and then reads both parts back. Each expected value is worked out in 32.32 arithmetic by counting the edges that added the old increment, the edge that took the write without an increment, and the edges that added the new one, so a design that lets the increment win or applies the new increment early lands on a different time.

// File: rtl/tod_pkg.sv
// Package: shared register-select type for the time-of-day counter.
// Assumes: the decode and register modules agree on this encoding only
// internally; it never appears at the block's ports.
package tod_pkg;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_FRAC = 3'd2,
        SEL_WHOLE = 3'd3,
        SEL_STEP = 3'd4
    } reg_sel_t;

endpackage

// File: rtl/tod_decode.sv
// Module: tod_decode
// Maps a register byte offset onto a register select. Purely combinational.
// Assumes: offsets must match in every bit; anything else selects nothing.
module tod_decode #(
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] OFS_CTRL = 12'hF00,
    parameter logic [11:0] OFS_FRAC = 12'hF08,
    parameter logic [11:0] OFS_WHOLE = 12'hF10,
    parameter logic [11:0] OFS_STEP = 12'hF18
) (
    input  logic [ADDR_W-1:0] addr,
    output tod_pkg::reg_sel_t sel
);

    // Full-width compare of the offset against each mapped register.
    always_comb begin
        if (addr == ADDR_W'(OFS_CTRL))       sel = tod_pkg::SEL_CTRL;
        else if (addr == ADDR_W'(OFS_FRAC))  sel = tod_pkg::SEL_FRAC;
        else if (addr == ADDR_W'(OFS_WHOLE)) sel = tod_pkg::SEL_WHOLE;
        else if (addr == ADDR_W'(OFS_STEP))  sel = tod_pkg::SEL_STEP;
        else                                 sel = tod_pkg::SEL_NONE;
    end

endmodule

// File: rtl/tod_regs.sv
// Module: tod_regs
// Holds the control and increment registers, raises load strobes for the
// accumulator, and drives the registered read data.
// Assumes: DATA_W is at least as wide as the whole count and the increment;
// read data holds its value between read requests.
module tod_regs #(
    parameter int DATA_W = 64,
    parameter int TIME_W = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic              req_wr,
    input  tod_pkg::reg_sel_t req_sel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TIME_W-1:0] cur_whole,
    input  logic [FRAC_W-1:0] cur_frac,
    output logic              cnt_en,
    output logic [STEP_W-1:0] step,
    output logic              ld_whole,
    output logic              ld_frac,
    output logic [DATA_W-1:0] rdata
);

    logic wr_hit;
    logic rd_hit;
    logic [DATA_W-1:0] rd_mux;

    assign wr_hit   = req_vld && req_wr;
    assign rd_hit   = req_vld && !req_wr;
    assign ld_whole = wr_hit && (req_sel == tod_pkg::SEL_WHOLE);
    assign ld_frac  = wr_hit && (req_sel == tod_pkg::SEL_FRAC);

    // Control bit: updated only by a write to the control offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      cnt_en <= 1'b0;
        else if (wr_hit && req_sel == tod_pkg::SEL_CTRL) cnt_en <= req_wdata[0];
    end

    // Increment register: updated only by a write to the increment offset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                      step <= '0;
        else if (wr_hit && req_sel == tod_pkg::SEL_STEP) step <= req_wdata[STEP_W-1:0];
    end

    // Read multiplexer over the current register state.
    always_comb begin
        unique case (req_sel)
            tod_pkg::SEL_CTRL:  rd_mux = DATA_W'(cnt_en);
            tod_pkg::SEL_FRAC:  rd_mux = DATA_W'(cur_frac);
            tod_pkg::SEL_WHOLE: rd_mux = DATA_W'(cur_whole);
            tod_pkg::SEL_STEP:  rd_mux = DATA_W'(step);
            default:            rd_mux = '0;
        endcase
    end

    // Read data register: captures the selected value on a read request.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (rd_hit) rdata <= rd_mux;
    end

endmodule

// File: rtl/tod_accum.sv
// Module: tod_accum
// Wide fixed-point time accumulator: whole nanoseconds above a fraction.
// Assumes: a load of either part takes priority over counting for the
// whole cycle, and the increment is zero-extended above its whole field.
module tod_accum #(
    parameter int TIME_W = 64,
    parameter int FRAC_W = 32,
    parameter int STEP_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [STEP_W-1:0] step,
    input  logic              ld_whole,
    input  logic              ld_frac,
    input  logic [TIME_W-1:0] ld_val,
    output logic [TIME_W-1:0] whole,
    output logic [FRAC_W-1:0] frac
);

    localparam int ACC_W = TIME_W + FRAC_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_sum;

    // Next value when counting: one full-width add so the fraction carries.
    assign acc_sum = acc_q + ACC_W'(step);

    // Accumulator update: loads win over counting, counting needs the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)        acc_q <= '0;
        else if (ld_whole) acc_q[ACC_W-1:FRAC_W] <= ld_val;
        else if (ld_frac)  acc_q[FRAC_W-1:0] <= ld_val[FRAC_W-1:0];
        else if (cnt_en)   acc_q <= acc_sum;
    end

    assign whole = acc_q[ACC_W-1:FRAC_W];
    assign frac  = acc_q[FRAC_W-1:0];

endmodule

// File: rtl/tod_counter.sv
// Module: tod_counter (top)
// Nanosecond time-of-day counter advanced by a programmable 32.32
// increment, with a single-cycle register port and registered read data.
// Assumes: one request per cycle at most; only a read moves reg_rdata.
module tod_counter #(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 64,
    parameter int          TIME_W    = 64,
    parameter int          FRAC_W    = 32,
    parameter int          STEP_INT_W = 32,
    parameter logic [11:0] OFS_CTRL  = 12'hF00,
    parameter logic [11:0] OFS_FRAC  = 12'hF08,
    parameter logic [11:0] OFS_WHOLE = 12'hF10,
    parameter logic [11:0] OFS_STEP  = 12'hF18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_vld,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int STEP_W = STEP_INT_W + FRAC_W;

    tod_pkg::reg_sel_t sel;
    logic              cnt_en;
    logic [STEP_W-1:0] step;
    logic              ld_whole;
    logic              ld_frac;
    logic [TIME_W-1:0] acc_whole;
    logic [FRAC_W-1:0] acc_frac;

    tod_decode #(
        .ADDR_W   (ADDR_W),
        .OFS_CTRL (OFS_CTRL),
        .OFS_FRAC (OFS_FRAC),
        .OFS_WHOLE(OFS_WHOLE),
        .OFS_STEP (OFS_STEP)
    ) u_decode (
        .addr(reg_addr),
        .sel (sel)
    );

    tod_regs #(
        .DATA_W(DATA_W),
        .TIME_W(TIME_W),
        .FRAC_W(FRAC_W),
        .STEP_W(STEP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_vld  (reg_vld),
        .req_wr   (reg_wr),
        .req_sel  (sel),
        .req_wdata(reg_wdata),
        .cur_whole(acc_whole),
        .cur_frac (acc_frac),
        .cnt_en   (cnt_en),
        .step     (step),
        .ld_whole (ld_whole),
        .ld_frac  (ld_frac),
        .rdata    (reg_rdata)
    );

    tod_accum #(
        .TIME_W(TIME_W),
        .FRAC_W(FRAC_W),
        .STEP_W(STEP_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .step    (step),
        .ld_whole(ld_whole),
        .ld_frac (ld_frac),
        .ld_val  (reg_wdata[TIME_W-1:0]),
        .whole   (acc_whole),
        .frac    (acc_frac)
    );

endmodule

// File: rtl/tod_counter_chk.sv
// Module: tod_counter_chk
// Temporal checks on the time-of-day counter, attached by bind.
// Assumes: the bound top exposes cnt_en, acc_whole and acc_frac.
module tod_counter_chk #(
    parameter int          ADDR_W    = 12,
    parameter int          DATA_W    = 64,
    parameter int          TIME_W    = 64,
    parameter int          FRAC_W    = 32,
    parameter logic [11:0] OFS_CTRL  = 12'hF00,
    parameter logic [11:0] OFS_FRAC  = 12'hF08,
    parameter logic [11:0] OFS_WHOLE = 12'hF10,
    parameter logic [11:0] OFS_STEP  = 12'hF18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_vld,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              cnt_en,
    input logic [TIME_W-1:0] acc_whole,
    input logic [FRAC_W-1:0] acc_frac
);

    logic wr_time;
    logic unmapped;

    assign wr_time  = reg_vld && reg_wr &&
                      (reg_addr == ADDR_W'(OFS_FRAC) || reg_addr == ADDR_W'(OFS_WHOLE));
    assign unmapped = reg_addr != ADDR_W'(OFS_CTRL) && reg_addr != ADDR_W'(OFS_FRAC) &&
                      reg_addr != ADDR_W'(OFS_WHOLE) && reg_addr != ADDR_W'(OFS_STEP);

    // R5
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !wr_time) |=> ($stable(acc_whole) && $stable(acc_frac)));

    // R8
    whole_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && reg_wr && reg_addr == ADDR_W'(OFS_WHOLE))
        |=> (acc_whole == $past(reg_wdata[TIME_W-1:0]) && $stable(acc_frac)));

    // R8
    frac_load_keeps_whole_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && reg_wr && reg_addr == ADDR_W'(OFS_FRAC))
        |=> (acc_frac == $past(reg_wdata[FRAC_W-1:0]) && $stable(acc_whole)));

    // R10
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && !reg_wr && unmapped) |=> (reg_rdata == '0));

    // R6
    frac_read_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && !reg_wr && reg_addr == ADDR_W'(OFS_FRAC))
        |=> (reg_rdata[DATA_W-1:FRAC_W] == '0));

    // R2
    ctrl_read_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_vld && !reg_wr && reg_addr == ADDR_W'(OFS_CTRL))
        |=> (reg_rdata[DATA_W-1:1] == '0));

endmodule

bind tod_counter tod_counter_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TIME_W   (TIME_W),
    .FRAC_W   (FRAC_W),
    .OFS_CTRL (OFS_CTRL),
    .OFS_FRAC (OFS_FRAC),
    .OFS_WHOLE(OFS_WHOLE),
    .OFS_STEP (OFS_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_vld  (reg_vld),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cnt_en   (cnt_en),
    .acc_whole(acc_whole),
    .acc_frac (acc_frac)
);

// File: tb/test_tod_counter.sv
`timescale 1ns/1ps
// Bench: scoreboard style. Read tasks queue the expected data; a monitor
// compares reg_rdata one cycle after each read request.
module test_tod_counter;

    localparam logic [11:0] A_CTRL  = 12'hF00;
    localparam logic [11:0] A_FRAC  = 12'hF08;
    localparam logic [11:0] A_WHOLE = 12'hF10;
    localparam logic [11:0] A_STEP  = 12'hF18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_vld = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic rd_seen = 1'b0;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    tod_counter i_tod_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_vld  (reg_vld),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    // Product N x increment in 32.32: returns whole (sel=1) or fraction.
    function automatic logic [63:0] n_times(input int n, input logic [63:0] inc, input bit want_whole);
        logic [95:0] p;
        p = 96'(n) * 96'(inc);
        return want_whole ? p[95:32] : 64'(p[31:0]);
    endfunction

    // Called at a negedge: drive one write for a single cycle.
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        reg_vld = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_vld = 1'b0; reg_wr = 1'b0;
    endtask

    // Called at a negedge: drive one read and queue its expected data.
    task automatic rd(input logic [11:0] a, input logic [63:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        reg_vld = 1'b1; reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_vld = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Marks the cycle after a read request was taken.
    always @(posedge clk) rd_seen <= rst_n && reg_vld && !reg_wr;

    // Monitor: compares the read data with the queue head.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if (reg_rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata=%h expected %h", t, reg_rdata, e);
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a miscompare.
    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: rdata=%h expected end of run", reg_rdata);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL,  64'h0, "R1 ctrl");
        rd(A_STEP,  64'h0, "R1 step");
        rd(A_WHOLE, 64'h0, "R1 whole");
        rd(A_FRAC,  64'h0, "R1 frac");

        // R2 read-back while stopped
        wr(A_STEP, 64'h0000_0002_8000_0000);
        rd(A_STEP, 64'h0000_0002_8000_0000, "R2 step");
        // R10 unmapped offsets
        wr(12'hF20, 64'hDEAD_BEEF_0000_0001);
        wr(12'hF04, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'hF20, 64'h0, "R10 read F20");
        rd(12'hF04, 64'h0, "R10 read F04");
        rd(A_STEP, 64'h0000_0002_8000_0000, "R10 step untouched");
        rd(A_CTRL, 64'h0, "R10 ctrl untouched");
        // R5 stopped with a nonzero increment
        idle(10);
        rd(A_WHOLE, 64'h0, "R5 whole held");

        // R4 R7 R3: increment 2.5 ns, 37 counted cycles before the read
        wr(A_CTRL, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(A_CTRL, 64'h1, "R2 ctrl bit0 only");
        idle(36);
        rd(A_WHOLE, n_times(37, 64'h0000_0002_8000_0000, 1), "R7 whole 2.5x37");
        rd(A_FRAC,  n_times(38, 64'h0000_0002_8000_0000, 0), "R3 frac next cycle");
        wr(A_CTRL, 64'h0);
        rd(A_WHOLE, n_times(40, 64'h0000_0002_8000_0000, 1), "R4 ctrl write counted");
        rd(A_WHOLE, n_times(40, 64'h0000_0002_8000_0000, 1), "R5 stopped again");

        // R7 non-integer increment over 1000 cycles
        wr(A_WHOLE, 64'h0);
        wr(A_FRAC, 64'h0);
        wr(A_STEP, 64'h0000_0001_4CCC_CCCD);
        wr(A_CTRL, 64'h1);
        idle(1000);
        rd(A_WHOLE, n_times(1000, 64'h0000_0001_4CCC_CCCD, 1), "R7 whole 1000");
        rd(A_FRAC,  n_times(1001, 64'h0000_0001_4CCC_CCCD, 0), "R7 frac 1001");
        wr(A_CTRL, 64'h0);
        rd(A_WHOLE, n_times(1003, 64'h0000_0001_4CCC_CCCD, 1), "R7 whole 1003");
        rd(A_FRAC,  n_times(1003, 64'h0000_0001_4CCC_CCCD, 0), "R6 frac 1003");

        // R8 whole write colliding with counting (1.5 ns increment)
        wr(A_FRAC, 64'h8000_0000);
        wr(A_WHOLE, 64'd100);
        wr(A_STEP, 64'h0000_0001_8000_0000);
        wr(A_CTRL, 64'h1);
        idle(3);                        // 100.5 -> 105.0
        wr(A_WHOLE, 64'd5000);          // load wins: 5000.0
        rd(A_WHOLE, 64'd5000, "R8 whole load wins");
        rd(A_FRAC, 64'h8000_0000, "R8 frac after load");   // 5001.5
        wr(A_CTRL, 64'h0);              // 5004.5
        rd(A_WHOLE, 64'd5004, "R8 whole after stop");
        rd(A_FRAC, 64'h8000_0000, "R8 frac after stop");

        // R9 increment change while counting, then fraction write collision
        wr(A_CTRL, 64'h1);
        idle(2);                        // 5007.5
        wr(A_STEP, 64'h0000_0003_0000_0000); // old step used: 5009.0
        idle(1);                        // new step: 5012.0
        wr(A_FRAC, 64'h4000_0000);      // load wins: 5012.25
        rd(A_WHOLE, 64'd5012, "R9 step change timing"); // then 5015.25
        wr(A_CTRL, 64'h0);              // 5018.25
        rd(A_WHOLE, 64'd5018, "R9 time undisturbed");
        rd(A_FRAC, 64'h4000_0000, "R8 frac load keeps whole");

        // R8 upper bits of a fraction write are ignored
        wr(A_FRAC, 64'hFFFF_FFFF_0000_0001);
        rd(A_FRAC, 64'h0000_0000_0000_0001, "R8 frac upper ignored");
        rd(A_WHOLE, 64'd5018, "R8 whole untouched");
        rd(A_STEP, 64'h0000_0003_0000_0000, "R2 step readback");

        idle(3);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R3: %0d reads unanswered, expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule